// File: doc/BRIEF.md
# Multi-Lane Command Dispatcher with Ordered Result Return

The block takes intersection commands from a host through a small AXI-Lite register window, holds them in a command FIFO, and hands each one to an idle worker lane. Up to eight lanes work at the same time. Each lane takes a variable number of cycles, so lanes can finish out of order. The block gives every issued command a 3-bit sequence tag. When a lane reports its result, the result is written into the reorder slot that the tag names. The host then reads results back strictly in issue order.

Because commands queue in a FIFO, a host can write a whole batch without waiting between commands. It pays the slow register round trip once for the batch and then collects the ordered results. Dispatch proceeds while other lanes are still busy, so lanes never wait on the host between commands. The worker lanes sit outside the block. They see a start pulse with a shared command bus and answer with a one-cycle done pulse carrying their result.

Top module: `lane_dispatch_top`

## Requirements
- R1: After reset the issued count, the retired count and the status register all read 0, and a result read returns the empty value 0x0000_0000.
- R2: A write to offset 0x00 queues bits [15:0] as a command and answers with bresp OKAY (2'b00). If the command FIFO (CMD_DEPTH entries) is full, the write is dropped and answered with SLVERR (2'b10).
- R3: Each cycle at most one command is dispatched. It goes to the lowest-numbered idle lane, marked by a one-cycle one-hot `lane_start` pulse while `lane_cmd` carries the command.
- R4: Commands receive 3-bit tags in issue order. At most 8 commands may be outstanding (issued and not yet read by the host); when 8 are outstanding, dispatch stalls.
- R5: A read of offset 0x04 returns results in issue order, whatever order the lanes finish in. The value is bit 31 = 1 and the result in bits [15:0], and the read removes that entry.
- R6: A read of offset 0x04 while the result for the next tag in order has not yet arrived returns 0x0000_0000. It removes nothing and leaves the retired count unchanged.
- R7: Offset 0x08 returns the number of commands dispatched to lanes. Offset 0x0C returns the number of results the host has read out. Both are 32-bit counts.
- R8: Offset 0x10 returns status. Bit 0 is busy (a command is queued or outstanding) and bits [15:8] hold the outstanding count.
- R9: A batch of commands written back to back is dispatched and completed with no further host action. A lane is started while earlier-started lanes are still working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_axil_awaddr | input | 5 | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | 5 | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| lane_start | output | LANES | One-hot start pulse per lane |
| lane_cmd | output | CMD_W | Command for the lane being started |
| lane_done | input | LANES | Lane completion pulse |
| lane_result | input | LANES*RES_W | Per-lane result, valid with lane_done |

## Verification
The bench gives the lanes latencies that fall with lane number, so later commands finish first. A design that returned results in completion order would hand back the wrong data at the first read. With the head lane still busy and younger results already parked, it reads the result register. A design that popped anyway, or popped any valid slot, would return non-empty data or advance the retired count. It fills the eight tag slots and the whole FIFO, then writes once more. A missing stall would show up as tag aliasing or an issued count past 8, and a missing full check as an OKAY response and an extra result. It logs which lane each start goes to, so a picker that rotated or favoured the highest lane would fail.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  localparam int AXI_DW = 32;
  localparam int AXI_AW = 5;

  typedef enum logic [AXI_AW-1:0] {
    OFS_CMD     = 5'h00,
    OFS_RESULT  = 5'h04,
    OFS_ISSUED  = 5'h08,
    OFS_RETIRED = 5'h0C,
    OFS_STATUS  = 5'h10
  } reg_ofs_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // status word: busy in bit 0, outstanding count from bit 8
  function automatic logic [AXI_DW-1:0] pack_status(input logic [7:0] outstanding,
                                                    input logic busy);
    return {16'h0000, outstanding, 7'b0, busy};
  endfunction

  // result word: valid flag in bit 31, payload in the low half
  function automatic logic [AXI_DW-1:0] pack_result(input logic [15:0] payload);
    return {1'b1, 15'b0, payload};
  endfunction
endpackage

// File: rtl/ldq_cmd_fifo.sv
module ldq_cmd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [PW:0]   count;

  assign empty = (count == '0);
  assign full  = (count == (PW+1)'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop)
        rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
    end
  end
endmodule

// File: rtl/ldq_lane_pick.sv
module ldq_lane_pick #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0]         busy,
  input  logic                     en,
  output logic [LANES-1:0]         grant,
  output logic [$clog2(LANES)-1:0] grant_idx,
  output logic                     any_idle
);
  localparam int IW = $clog2(LANES);

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any_idle  = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        grant_idx = IW'(i);
        any_idle  = 1'b1;
      end
    end
    if (en && any_idle)
      grant[grant_idx] = 1'b1;
  end
endmodule

// File: rtl/ldq_reorder.sv
module ldq_reorder #(
  parameter int LANES = 8,
  parameter int RES_W = 16,
  parameter int TAG_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       done,
  input  logic [LANES*TAG_W-1:0] done_tag,
  input  logic [LANES*RES_W-1:0] done_res,
  input  logic                   pop,
  output logic                   head_valid,
  output logic [RES_W-1:0]       head_data
);
  localparam int SLOTS = 1 << TAG_W;

  logic [SLOTS-1:0] slot_vld;
  logic [RES_W-1:0] slot_dat [SLOTS];
  logic [TAG_W-1:0] head_tag;

  assign head_valid = slot_vld[head_tag];
  assign head_data  = slot_dat[head_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
      head_tag <= '0;
    end else begin
      if (pop) begin
        slot_vld[head_tag] <= 1'b0;
        head_tag <= head_tag + 1'b1;
      end
      for (int l = 0; l < LANES; l++) begin
        if (done[l]) begin
          slot_vld[done_tag[l*TAG_W +: TAG_W]] <= 1'b1;
          slot_dat[done_tag[l*TAG_W +: TAG_W]] <= done_res[l*RES_W +: RES_W];
        end
      end
    end
  end
endmodule

// File: rtl/lane_dispatch_top.sv
module lane_dispatch_top
  import ldq_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int CMD_W     = 16,
  parameter int RES_W     = 16,
  parameter int CMD_DEPTH = 16,
  parameter int TAG_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             s_axil_awaddr,
  input  logic                   s_axil_awvalid,
  output logic                   s_axil_awready,
  input  logic [31:0]            s_axil_wdata,
  input  logic                   s_axil_wvalid,
  output logic                   s_axil_wready,
  output logic [1:0]             s_axil_bresp,
  output logic                   s_axil_bvalid,
  input  logic                   s_axil_bready,
  input  logic [4:0]             s_axil_araddr,
  input  logic                   s_axil_arvalid,
  output logic                   s_axil_arready,
  output logic [31:0]            s_axil_rdata,
  output logic [1:0]             s_axil_rresp,
  output logic                   s_axil_rvalid,
  input  logic                   s_axil_rready,
  output logic [LANES-1:0]       lane_start,
  output logic [CMD_W-1:0]       lane_cmd,
  input  logic [LANES-1:0]       lane_done,
  input  logic [LANES*RES_W-1:0] lane_result
);
  localparam int SLOTS = 1 << TAG_W;
  localparam int IW    = $clog2(LANES);

  // named internal events, observed by the bound checker
  logic              wr_accept, rd_accept, cmd_push, res_pop, dispatch_fire;
  logic              fifo_empty, fifo_full, any_idle, head_valid, room;
  logic [CMD_W-1:0]  fifo_head;
  logic [RES_W-1:0]  head_data;
  logic [LANES-1:0]  lane_busy, grant;
  logic [IW-1:0]     grant_idx;
  logic [TAG_W-1:0]  issue_tag;
  logic [TAG_W:0]    outstanding;
  logic [31:0]       issued_cnt, retired_cnt;
  logic [TAG_W-1:0]  lane_tag_q [LANES];
  logic [LANES*TAG_W-1:0] lane_tag_flat;
  logic              unused_wdata;

  assign unused_wdata = ^s_axil_wdata[31:CMD_W];

  // write channel: address and data taken together
  assign s_axil_awready = !s_axil_bvalid;
  assign s_axil_wready  = !s_axil_bvalid;
  assign wr_accept = s_axil_awvalid && s_axil_wvalid && !s_axil_bvalid;
  assign cmd_push  = wr_accept && (s_axil_awaddr == OFS_CMD) && !fifo_full;

  // read channel
  assign s_axil_arready = !s_axil_rvalid;
  assign s_axil_rresp   = RESP_OKAY;
  assign rd_accept = s_axil_arvalid && !s_axil_rvalid;
  assign res_pop   = rd_accept && (s_axil_araddr == OFS_RESULT) && head_valid;

  // dispatch
  assign room          = (outstanding < (TAG_W+1)'(SLOTS));
  assign dispatch_fire = !fifo_empty && any_idle && room;
  assign lane_start    = grant;
  assign lane_cmd      = fifo_head;

  ldq_cmd_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(cmd_push), .din(s_axil_wdata[CMD_W-1:0]),
    .pop(dispatch_fire), .dout(fifo_head),
    .empty(fifo_empty), .full(fifo_full)
  );

  ldq_lane_pick #(.LANES(LANES)) u_pick (
    .busy(lane_busy), .en(!fifo_empty && room),
    .grant(grant), .grant_idx(grant_idx), .any_idle(any_idle)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_tag
    assign lane_tag_flat[g*TAG_W +: TAG_W] = lane_tag_q[g];
  end

  ldq_reorder #(.LANES(LANES), .RES_W(RES_W), .TAG_W(TAG_W)) u_rob (
    .clk(clk), .rst_n(rst_n),
    .done(lane_done & lane_busy), .done_tag(lane_tag_flat),
    .done_res(lane_result), .pop(res_pop),
    .head_valid(head_valid), .head_data(head_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_busy   <= '0;
      issue_tag   <= '0;
      outstanding <= '0;
      issued_cnt  <= '0;
      retired_cnt <= '0;
      for (int l = 0; l < LANES; l++) lane_tag_q[l] <= '0;
    end else begin
      lane_busy <= (lane_busy & ~lane_done) | grant;
      if (dispatch_fire) begin
        lane_tag_q[grant_idx] <= issue_tag;
        issue_tag  <= issue_tag + 1'b1;
        issued_cnt <= issued_cnt + 1;
      end
      if (res_pop) retired_cnt <= retired_cnt + 1;
      outstanding <= outstanding + (TAG_W+1)'(dispatch_fire) - (TAG_W+1)'(res_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_axil_bvalid <= 1'b0;
      s_axil_bresp  <= RESP_OKAY;
      s_axil_rvalid <= 1'b0;
      s_axil_rdata  <= '0;
    end else begin
      if (wr_accept) begin
        s_axil_bvalid <= 1'b1;
        s_axil_bresp  <= ((s_axil_awaddr == OFS_CMD) && fifo_full) ? RESP_SLVERR : RESP_OKAY;
      end else if (s_axil_bready) begin
        s_axil_bvalid <= 1'b0;
      end
      if (rd_accept) begin
        s_axil_rvalid <= 1'b1;
        case (s_axil_araddr)
          OFS_RESULT:  s_axil_rdata <= head_valid ? pack_result(16'(head_data)) : '0;
          OFS_ISSUED:  s_axil_rdata <= issued_cnt;
          OFS_RETIRED: s_axil_rdata <= retired_cnt;
          OFS_STATUS:  s_axil_rdata <= pack_status(8'(outstanding),
                                                   !fifo_empty || (outstanding != '0));
          default:     s_axil_rdata <= '0;
        endcase
      end else if (s_axil_rready) begin
        s_axil_rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ldq_checker.sv
module ldq_checker #(
  parameter int LANES = 8,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_start,
  input logic [LANES-1:0] lane_busy,
  input logic             dispatch_fire,
  input logic             res_pop,
  input logic             head_valid,
  input logic [TAG_W:0]   outstanding,
  input logic [31:0]      issued_cnt,
  input logic [31:0]      retired_cnt
);
  localparam int SLOTS = 1 << TAG_W;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= (TAG_W+1)'(SLOTS));

  // R4
  outstanding_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding) == issued_cnt - retired_cnt);

  // R3
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_start));

  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_start & lane_busy) == '0);

  // R3
  start_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_fire |-> (((lane_start - 1'b1) & ~lane_busy) == '0));

  // R6
  pop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_pop |-> head_valid);

  // R7
  issued_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_fire |=> issued_cnt == $past(issued_cnt) + 32'd1);

  // R7
  retired_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retired_cnt <= issued_cnt);
endmodule

bind lane_dispatch_top ldq_checker #(.LANES(LANES), .TAG_W(TAG_W)) u_ldq_chk (
  .clk(clk), .rst_n(rst_n),
  .lane_start(lane_start), .lane_busy(lane_busy),
  .dispatch_fire(dispatch_fire), .res_pop(res_pop), .head_valid(head_valid),
  .outstanding(outstanding), .issued_cnt(issued_cnt), .retired_cnt(retired_cnt)
);

// File: tb/lane_dispatch_top_test.sv
`timescale 1ns/1ps
module lane_dispatch_top_test;
  localparam int LANES = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0] wdata = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [LANES-1:0]    start;
  logic [15:0]         lcmd;
  logic [LANES-1:0]    done = '0;
  logic [LANES*16-1:0] lres = '0;

  lane_dispatch_top uut (
    .clk(clk), .rst_n(rst_n),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wvalid(wvalid), .s_axil_wready(wready),
    .s_axil_bresp(bresp), .s_axil_bvalid(bvalid), .s_axil_bready(1'b1),
    .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready),
    .s_axil_rdata(rdata), .s_axil_rresp(rresp), .s_axil_rvalid(rvalid),
    .s_axil_rready(1'b1),
    .lane_start(start), .lane_cmd(lcmd), .lane_done(done), .lane_result(lres)
  );

  // lane stubs: latency falls with lane index, result is the inverted command
  int          cnt [LANES];
  logic [15:0] held [LANES];
  int          log_lane [64];
  int          nlog = 0;
  initial for (int l = 0; l < LANES; l++) cnt[l] = 0;

  always @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      done[l] <= 1'b0;
      if (start[l]) begin
        cnt[l]  <= 100 - 10 * l;
        held[l] <= lcmd;
        if (nlog < 64) log_lane[nlog] = l;
        nlog = nlog + 1;
      end else if (cnt[l] > 0) begin
        cnt[l] <= cnt[l] - 1;
        if (cnt[l] == 1) begin
          done[l] <= 1'b1;
          lres[l*16 +: 16] <= ~held[l];
        end
      end
    end
  end

  // {command, expected result}
  localparam logic [31:0] VEC [12] = '{
    {16'h0001, 16'hFFFE}, {16'h0010, 16'hFFEF}, {16'h0100, 16'hFEFF},
    {16'h1000, 16'hEFFF}, {16'h00FF, 16'hFF00}, {16'hFF00, 16'h00FF},
    {16'h1234, 16'hEDCB}, {16'hABCD, 16'h5432}, {16'h5555, 16'hAAAA},
    {16'hAAAA, 16'h5555}, {16'h0F0F, 16'hF0F0}, {16'hF0F0, 16'h0F0F}
  };

  int n_vec = 0, n_bad = 0;
  bit ended = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, output logic [1:0] resp);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    resp = bresp;
    awvalid = 0; wvalid = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    d = rdata;
    arvalid = 0;
  endtask

  task automatic drain_one(input string req, input logic [15:0] exp);
    logic [31:0] d;
    int tries = 0;
    rd(5'h04, d);
    while (!d[31] && tries < 1000) begin
      rd(5'h04, d);
      tries++;
    end
    check(req, d, {1'b1, 15'b0, exp});
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(5'h10, d); check("R1 status", d, 32'h0);
    rd(5'h08, d); check("R1 issued", d, 32'h0);
    rd(5'h0C, d); check("R1 retired", d, 32'h0);
    rd(5'h04, d); check("R1 empty result", d, 32'h0);
    rd(5'h0C, d); check("R6 no pop when empty", d, 32'h0);

    // R9 batch of 12 written back to back
    for (int i = 0; i < 12; i++) begin
      wr(5'h00, {16'h0, VEC[i][31:16]}, r);
      check("R2 bresp okay", {30'b0, r}, 32'h0);
    end
    repeat (30) @(negedge clk);
    // lane 0 (head) still working, younger lanes finished: R6 and R4
    rd(5'h04, d); check("R6 head not ready", d, 32'h0);
    rd(5'h0C, d); check("R6 retired unchanged", d, 32'h0);
    rd(5'h08, d); check("R4 stall at eight outstanding", d, 32'd8);
    rd(5'h10, d); check("R8 status busy", d, 32'h0000_0801);
    for (int k = 0; k < 8; k++) check("R3 lowest idle lane", log_lane[k], k);

    // R5 ordered return of the whole batch
    for (int i = 0; i < 12; i++) drain_one("R5 ordered result", VEC[i][15:0]);
    check("R3 freed lane zero reused", log_lane[8], 0);
    rd(5'h04, d); check("R6 empty after drain", d, 32'h0);
    rd(5'h08, d); check("R7 issued", d, 32'd12);
    rd(5'h0C, d); check("R7 retired", d, 32'd12);
    rd(5'h10, d); check("R8 status idle", d, 32'h0);

    // R2 full FIFO: 8 outstanding plus DEPTH queued, then one more
    for (int k = 0; k < 8 + DEPTH; k++) begin
      wr(5'h00, 32'h0000_0100 + k, r);
      check("R2 bresp okay while room", {30'b0, r}, 32'h0);
    end
    wr(5'h00, 32'h0000_BEEF, r);
    check("R2 bresp slverr when full", {30'b0, r}, 32'h2);
    rd(5'h08, d); check("R4 issued stalls", d, 32'd20);
    for (int k = 0; k < 8 + DEPTH; k++) drain_one("R5 ordered after refill", ~(16'h0100 + 16'(k)));
    rd(5'h04, d); check("R2 dropped write left no result", d, 32'h0);
    rd(5'h08, d); check("R7 issued total", d, 32'd36);
    rd(5'h0C, d); check("R7 retired total", d, 32'd36);
    rd(5'h10, d); check("R8 final status", d, 32'h0);
    check("R1 rresp okay", {30'b0, rresp}, 32'h0);
    finish_run();
  end
endmodule